// File: doc/BRIEF.md
# Unsigned Truncated Multiplier with Overflow Flag

This block multiplies two unsigned N-bit operands. It returns only the low N bits of the product and a flag that is high when the true product does not fit in N bits. It is purely combinational and has no clock or reset.

The block never builds the upper half of the partial-product array. A reduced array of AND-gated adder cells forms the product bits from column 0 up to column N. The cells in column N form a sum only and produce no carry. In parallel, a linear chain of OR/AND stages scans the operands for bit patterns that force an overflow. The output flag is the chain result ORed with product bit N.

A value's significant bits are its highest set bit plus every bit below it. The value zero has none. The chain fires when the significant-bit counts of the two operands add up to N+2 or more.

Top module: `umul_ovf`

## Requirements
- R1: `prod_lo` always equals bits N-1..0 of the exact 2N-bit product `opa*opb`.
- R2: `ovf` is 1 exactly when the exact product is 2^N or larger, that is, when its bits 2N-1..N are not all zero.
- R3: The significant-bit count of a value is the position of its highest set bit plus one, and 0 for a zero value. When the counts of `opa` and `opb` add up to N+2 or more, `ovf` is 1 (for example 0x80 times 0x02 at N=8).
- R4: When the significant-bit counts add up to N or less, `ovf` is 0 (for example 0x0F times 0x0F gives 0xE1 with no overflow).
- R5: When the significant-bit counts add up to exactly N+1, `ovf` equals bit N of the exact product (0x1F times 0x0F overflows; 0x10 times 0x08 does not).
- R6: A zero on either operand gives `prod_lo` = 0 and `ovf` = 0, whatever the other operand is.
- R7: An operand equal to 1 passes the other operand through unchanged to `prod_lo`, with `ovf` = 0.
- R8: All-ones times all-ones gives `prod_lo` = 1 and `ovf` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | Unsigned multiplicand |
| opb | input | N | Unsigned multiplier |
| prod_lo | output | N | Low N bits of the product |
| ovf | output | 1 | High when the product needs more than N bits |

## Verification
The block holds no state. A wrong internal value therefore appears at the outputs in the same evaluation as the operands that trigger it, and the next operand pair clears it. A broken carry cell in the reduced array changes `prod_lo`, or product bit N, and through that bit the flag. A broken stage in the overflow chain shows only on operand pairs whose significant-bit counts add up to N+2 or more, as a flag that stays low. For this reason the bench covers all operand pairs at N=8 and sorts each one by its significant-bit sum.

// File: rtl/umul_ovf_pkg.sv
package umul_ovf_pkg;

    // Full-adder sum bit of the modified cell
    function automatic logic fa_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    // Full-adder carry bit of the modified cell
    function automatic logic fa_cy(input logic x, input logic y, input logic ci);
        return (x & y) | (x & ci) | (y & ci);
    endfunction

    // Top-column cell: sum only, its carry would land beyond bit N
    function automatic logic top_sum(input logic pp, input logic s_in, input logic c_in);
        return pp ^ s_in ^ c_in;
    endfunction

endpackage

// File: rtl/umul_lo_array.sv
// Reduced multiplier array: builds product columns 0..N only.
module umul_lo_array
    import umul_ovf_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    output logic [N:0]   lo
);
    localparam int W = N + 1;

    always_comb begin
        logic [W-1:0] acc;
        logic [W-1:0] ax;
        logic         cin;
        logic         pp;
        ax  = {1'b0, opa};
        acc = '0;
        for (int j = 0; j < N; j++) begin
            cin = 1'b0;
            for (int k = 0; k < W; k++) begin
                if (k >= j) begin
                    pp = ax[k - j] & opb[j];
                    if (k < N) begin
                        logic s;
                        s      = fa_sum(acc[k], pp, cin);
                        cin    = fa_cy(acc[k], pp, cin);
                        acc[k] = s;
                    end else begin
                        acc[k] = top_sum(pp, acc[k], cin);
                    end
                end
            end
        end
        lo = acc;
    end

endmodule

// File: rtl/umul_ovf_chain.sv
// Linear detector for operand patterns that force an overflow.
module umul_ovf_chain #(
    parameter int N = 8
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    output logic         pre_ovf
);
    always_comb begin
        logic any_hi;
        logic hit;
        any_hi = opa[N-1];
        hit    = opa[N-1] & opb[1];
        for (int i = 2; i < N; i++) begin
            any_hi = any_hi | opa[N - i];
            hit    = hit | (any_hi & opb[i]);
        end
        pre_ovf = hit;
    end

endmodule

// File: rtl/umul_ovf.sv
// Unsigned N x N multiplier returning N low bits plus overflow flag. N >= 4.
module umul_ovf #(
    parameter int N = 8
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    output logic [N-1:0] prod_lo,
    output logic         ovf
);
    logic [N:0] lo_w;
    logic       pre_w;

    umul_lo_array #(.N(N)) i_array (
        .opa (opa),
        .opb (opb),
        .lo  (lo_w)
    );

    umul_ovf_chain #(.N(N)) i_chain (
        .opa     (opa),
        .opb     (opb),
        .pre_ovf (pre_w)
    );

    assign prod_lo = lo_w[N-1:0];
    assign ovf     = pre_w | lo_w[N];

endmodule

// File: rtl/umul_ovf_chk.sv
module umul_ovf_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] opa,
    input logic [N-1:0] opb,
    input logic [N-1:0] prod_lo,
    input logic         ovf
);
    localparam int W2 = 2 * N;

    function automatic int sig_cnt(input logic [N-1:0] x);
        int c;
        c = 0;
        for (int i = 0; i < N; i++) if (x[i]) c = i + 1;
        return c;
    endfunction

    logic [W2-1:0] exact;
    int            ssum;
    assign exact = {{N{1'b0}}, opa} * {{N{1'b0}}, opb};
    assign ssum  = sig_cnt(opa) + sig_cnt(opb);

    always_comb begin
        AST_LOW_BITS: assert (prod_lo == exact[N-1:0]) else $error("low bits"); // R1
        AST_FLAG_EXACT: assert (ovf == (exact[W2-1:N] != '0)) else $error("flag"); // R2
        AST_MUST_OVERFLOW: assert (!(ssum >= N + 2) || ovf) else $error("must"); // R3
        AST_NO_OVERFLOW: assert (!(ssum <= N) || !ovf) else $error("never"); // R4
        AST_BORDER_BIT: assert (!(ssum == N + 1) || (ovf == exact[N])) else $error("border"); // R5
        AST_ZERO_OPERAND: assert (!(opa == '0 || opb == '0) || (prod_lo == '0 && !ovf)) else $error("zero"); // R6
        AST_UNIT_OPERAND: assert (!(opb == N'(1)) || (prod_lo == opa && !ovf)) else $error("unit"); // R7
    end

endmodule

bind umul_ovf umul_ovf_chk #(.N(N)) i_umul_ovf_chk (
    .opa     (opa),
    .opb     (opb),
    .prod_lo (prod_lo),
    .ovf     (ovf)
);

// File: tb/test_umul_ovf.sv
module test_umul_ovf;
    localparam int N = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [N-1:0] opa, opb, prod_lo;
    logic         ovf;
    int           total = 0;
    int           bad   = 0;

    umul_ovf #(.N(N)) i_umul_ovf (
        .opa     (opa),
        .opb     (opb),
        .prod_lo (prod_lo),
        .ovf     (ovf)
    );

    // {opa, opb, expected prod_lo, expected ovf, requirement number}
    localparam logic [28:0] TAB [0:15] = '{
        {8'h00, 8'h00, 8'h00, 1'b0, 4'd6},  // R6
        {8'h00, 8'hFF, 8'h00, 1'b0, 4'd6},  // R6
        {8'hFF, 8'h00, 8'h00, 1'b0, 4'd6},  // R6
        {8'h01, 8'hB7, 8'hB7, 1'b0, 4'd7},  // R7
        {8'h5A, 8'h01, 8'h5A, 1'b0, 4'd7},  // R7
        {8'h80, 8'h01, 8'h80, 1'b0, 4'd7},  // R7
        {8'hFF, 8'hFF, 8'h01, 1'b1, 4'd8},  // R8
        {8'h80, 8'h02, 8'h00, 1'b1, 4'd3},  // R3
        {8'h10, 8'h10, 8'h00, 1'b1, 4'd3},  // R3
        {8'h11, 8'h10, 8'h10, 1'b1, 4'd3},  // R3
        {8'h0F, 8'h0F, 8'hE1, 1'b0, 4'd4},  // R4
        {8'h1F, 8'h0F, 8'hD1, 1'b1, 4'd5},  // R5
        {8'h10, 8'h08, 8'h80, 1'b0, 4'd5},  // R5
        {8'hFF, 8'h01, 8'hFF, 1'b0, 4'd5},  // R5
        {8'h0D, 8'h13, 8'hF7, 1'b0, 4'd1},  // R1
        {8'h11, 8'h0F, 8'hFF, 1'b0, 4'd2}   // R2
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h actual=%0h expected=%0h", tag, opa, opb, act, exp);
        end
    endtask

    function automatic int sig_cnt(input logic [N-1:0] x);
        int c;
        c = 0;
        for (int i = 0; i < N; i++) if (x[i]) c = i + 1;
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        opa = '0;
        opb = '0;
        @(negedge clk);
        chk("R6 idle product", int'(prod_lo), 0);
        chk("R6 idle flag", int'(ovf), 0);

        for (int t = 0; t < 16; t++) begin
            @(posedge clk);
            opa = TAB[t][28:21];
            opb = TAB[t][20:13];
            @(negedge clk);
            chk($sformatf("R%0d table product", int'(TAB[t][3:0])), int'(prod_lo), int'(TAB[t][12:5]));
            chk($sformatf("R%0d table flag", int'(TAB[t][3:0])), int'(ovf), int'(TAB[t][4]));
        end

        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                int full;
                int ss;
                @(posedge clk);
                opa = N'(x);
                opb = N'(y);
                full = x * y;
                ss   = sig_cnt(N'(x)) + sig_cnt(N'(y));
                @(negedge clk);
                chk("R1 low bits", int'(prod_lo), full % 256);
                chk("R2 flag", int'(ovf), (full >= 256) ? 1 : 0);
                if (ss >= N + 2) chk("R3 forced overflow", int'(ovf), 1);
                else if (ss <= N) chk("R4 no overflow", int'(ovf), 0);
                else chk("R5 border bit", int'(ovf), (full >> 8) & 1);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule